// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational binary adder. It takes two operands and a carry-in, and it returns the sum and a carry-out. The operand width is split into select groups whose widths grow toward the most significant end. Because of this, the carry that arrives at each group reaches its multiplexer at about the same time as the group's own precomputed results.

The lowest group is an ordinary ripple adder driven by the external carry-in. Each higher group computes two candidate results ahead of time. One assumes an incoming carry of 0 and the other assumes 1. The carry that leaves the group below chooses between them, covering both the sum bits and the group's outgoing carry. A build parameter selects how the carry-of-1 candidate is made:
- An increment stage, one bit wider than the group, applied to the carry-of-0 result.
- A second ripple adder with its carry-in tied high.

Both variants return the same results. They differ only in area and in delay.

Group widths follow the sequence 2, 2, 3, 4, 5, … with each group one bit wider than the one before it after the second. The last group is cut short so that the widths add up to exactly the operand width. At 16 bits this gives five groups. At 128 bits it gives sixteen groups, and the last one is 7 bits wide.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every input, {cout, s} equals the unsigned value a + b + cin, computed to WIDTH+1 bits.
- R2: With a all ones, b zero and cin = 1, s is all zeros and cout is 1.
- R3: With a and b both zero, s equals cin, with cin in bit 0 and zeros above it, and cout is 0.
- R4: A carry that is produced just below any group boundary shows up in the next group. Adding a = 2^k − 1 and b = 1 with cin = 0 gives s = 2^k and cout = 0. Here k is the lowest bit of each group: 2, 4, 7 and 11 at 16 bits, and 2, 4, 7, 11, 16, … at 128 bits.
- R5: a = 1000, b = 1000 and cin = 0 give s = 2000 and cout = 0.
- R6: The variant with a second ripple adder (USE_BEC = 0) meets R1 to R5 in the same way as the increment-stage variant (USE_BEC = 1).
- R7: A 128-bit instance, built from sixteen groups with a truncated last group, meets R1 over random and corner operands.
- R8: cout is 1 exactly when a + b + cin is 2^WIDTH or more, as carried by the top group's selected carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| s | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The block holds no state, so every result belongs to the cycle in which its operands are applied. The latency is zero clock edges. The bench changes the operands just after a rising edge of its pacing clock. It reads s and cout at the following falling edge, half a period later, when the whole carry path has settled. Each vector is applied at the same time to the 16-bit and 128-bit instances of both variants, and each instance is compared with an independently computed sum.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Width a group would have if the operand were unbounded: 2, 2, 3, 4, ...
    function automatic int grp_nominal(input int g);
        return (g == 0) ? 2 : g + 1;
    endfunction

    // Lowest bit position of group g inside an n-bit operand
    function automatic int grp_lsb(input int n, input int g);
        int acc;
        acc = 0;
        for (int k = 0; k < g; k++) begin
            acc += grp_nominal(k);
        end
        if (acc > n) acc = n;
        return acc;
    endfunction

    // Actual width of group g, the last group trimmed to fit
    function automatic int grp_width(input int n, input int g);
        int lo;
        int w;
        lo = grp_lsb(n, g);
        w  = grp_nominal(g);
        if (lo + w > n) w = n - lo;
        return w;
    endfunction

    // Number of groups needed to cover n bits
    function automatic int grp_count(input int n);
        int acc;
        int cnt;
        acc = 0;
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            if (acc < n) begin
                acc += grp_nominal(k);
                cnt++;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/csa_rca.sv
module csa_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain_d;

    assign chain_d[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic half_d;
        assign half_d       = a[i] ^ b[i];
        assign s[i]         = half_d ^ chain_d[i];
        assign chain_d[i+1] = (a[i] & b[i]) | (half_d & chain_d[i]);
    end

    assign co = chain_d[W];
endmodule

// File: rtl/csa_bec.sv
module csa_bec #(
    parameter int W = 5
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // running AND of all lower bits: toggle bit i when all below are set
    logic [W:0] all_ones_d;

    assign all_ones_d[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i]         = din[i] ^ all_ones_d[i];
        assign all_ones_d[i+1] = all_ones_d[i] & din[i];
    end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int W       = 3,
    parameter bit USE_BEC = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] sum0_d;
    logic         car0_d;
    logic [W-1:0] sum1_d;
    logic         car1_d;

    csa_rca #(.W(W)) u_rca0 (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (sum0_d),
        .co (car0_d)
    );

    if (USE_BEC) begin : g_bec
        // {car0, sum0} + 1 never exceeds W+1 bits
        csa_bec #(.W(W + 1)) u_inc (
            .din  ({car0_d, sum0_d}),
            .dout ({car1_d, sum1_d})
        );
    end else begin : g_dual
        csa_rca #(.W(W)) u_rca1 (
            .a  (a),
            .b  (b),
            .ci (1'b1),
            .s  (sum1_d),
            .co (car1_d)
        );
    end

    always_comb begin
        if (sel) begin
            s  = sum1_d;
            co = car1_d;
        end else begin
            s  = sum0_d;
            co = car0_d;
        end
    end
endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder #(
    parameter int WIDTH   = 16,
    parameter bit USE_BEC = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] s,
    output logic             cout
);
    localparam int NGRP = csa_pkg::grp_count(WIDTH);

    logic [NGRP:0]    carry_d;
    logic [WIDTH-1:0] sum_d;

    assign carry_d[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = csa_pkg::grp_lsb(WIDTH, g);
        localparam int GW = csa_pkg::grp_width(WIDTH, g);

        if (g == 0) begin : g_base
            csa_rca #(.W(GW)) u_rca (
                .a  (a[LO +: GW]),
                .b  (b[LO +: GW]),
                .ci (carry_d[0]),
                .s  (sum_d[LO +: GW]),
                .co (carry_d[1])
            );
        end else begin : g_sel
            csa_group #(.W(GW), .USE_BEC(USE_BEC)) u_grp (
                .a   (a[LO +: GW]),
                .b   (b[LO +: GW]),
                .sel (carry_d[g]),
                .s   (sum_d[LO +: GW]),
                .co  (carry_d[g+1])
            );
        end
    end

    assign s    = sum_d;
    assign cout = carry_d[NGRP];
endmodule

// File: rtl/csa_sqrt_adder_chk.sv
module csa_sqrt_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] s,
    input logic             cout
);
    logic [WIDTH:0] ref_d;

    assign ref_d = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        if (!$isunknown({a, b, cin, s, cout})) begin
            assert_sum_R1: assert ({cout, s} == ref_d)
                else $error("sum mismatch");
            assert_cout_R8: assert (cout == ref_d[WIDTH])
                else $error("carry-out mismatch");
            if (a == '0 && b == '0) begin
                assert_zero_R3: assert (s == {{(WIDTH-1){1'b0}}, cin} && !cout)
                    else $error("zero operands");
            end
            if (a == '1 && b == '0 && cin) begin
                assert_wrap_R2: assert (s == '0 && cout)
                    else $error("all-ones wrap");
            end
        end
    end
endmodule

bind csa_sqrt_adder csa_sqrt_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .s    (s),
    .cout (cout)
);

// File: tb/csa_sqrt_adder_bench.sv
module csa_sqrt_adder_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] a_w = '0;
    logic [127:0] b_w = '0;
    logic         ci  = 1'b0;

    logic [15:0]  s16b, s16r;
    logic         c16b, c16r;
    logic [127:0] s128b, s128r;
    logic         c128b, c128r;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    csa_sqrt_adder #(.WIDTH(16), .USE_BEC(1'b1)) u_csa_sqrt_adder (
        .a(a_w[15:0]), .b(b_w[15:0]), .cin(ci), .s(s16b), .cout(c16b));
    csa_sqrt_adder #(.WIDTH(16), .USE_BEC(1'b0)) u_reg16 (
        .a(a_w[15:0]), .b(b_w[15:0]), .cin(ci), .s(s16r), .cout(c16r));
    csa_sqrt_adder #(.WIDTH(128), .USE_BEC(1'b1)) u_bec128 (
        .a(a_w), .b(b_w), .cin(ci), .s(s128b), .cout(c128b));
    csa_sqrt_adder #(.WIDTH(128), .USE_BEC(1'b0)) u_reg128 (
        .a(a_w), .b(b_w), .cin(ci), .s(s128r), .cout(c128r));

    function automatic logic [16:0] exp16(input logic [15:0] x, input logic [15:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    function automatic logic [128:0] exp128(input logic [127:0] x, input logic [127:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {128'd0, c};
    endfunction

    task automatic check(input string req, input string what, input logic [128:0] act, input logic [128:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive after a rising edge, compare at the falling edge (zero latency)
    task automatic apply(input logic [127:0] x, input logic [127:0] y, input logic c, input string req);
        logic [16:0]  e16;
        logic [128:0] e128;
        @(posedge clk);
        a_w = x;
        b_w = y;
        ci  = c;
        @(negedge clk);
        e16  = exp16(x[15:0], y[15:0], c);
        e128 = exp128(x, y, c);
        check(req, "bec16",  {112'd0, c16b, s16b}, {112'd0, e16});
        check({req, "/R6"}, "reg16", {112'd0, c16r, s16r}, {112'd0, e16});
        check({req, "/R7"}, "bec128", {c128b, s128b}, e128);
        check({req, "/R6/R7"}, "reg128", {c128r, s128r}, e128);
        check("R8", "cout16", {128'd0, c16b}, {128'd0, e16[16]});
        check("R8", "cout128", {128'd0, c128b}, {128'd0, e128[128]});
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lo;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state: zero operands, zero result (R3)
        @(negedge clk);
        check("R3", "reset s16", {112'd0, c16b, s16b}, 129'd0);
        check("R3", "reset s128", {c128b, s128b}, 129'd0);

        apply('0, '0, 1'b1, "R3");
        apply('1, '0, 1'b1, "R2");
        apply('0, '1, 1'b1, "R2");
        apply('1, '1, 1'b1, "R1");
        apply(128'd1000, 128'd1000, 1'b0, "R5");

        // carry into each group's lowest bit (R4): widths 2,2,3,4,...
        lo = 2;
        for (int g = 1; g < 16; g++) begin
            apply((128'd1 << lo) - 128'd1, 128'd1, 1'b0, "R4");
            lo += g + 1;
        end
        // same boundaries reached through carry-in
        lo = 2;
        for (int g = 1; g < 16; g++) begin
            apply((128'd1 << lo) - 128'd1, 128'd0, 1'b1, "R4");
            lo += g + 1;
        end

        // random stimulus with some long-carry patterns (R1)
        for (int i = 0; i < 400; i++) begin
            logic [127:0] x;
            logic [127:0] y;
            x = {$urandom, $urandom, $urandom, $urandom};
            case ($urandom % 4)
                0: y = ~x;
                1: y = {$urandom, $urandom, $urandom, $urandom} & {4{32'h0000ffff}};
                default: y = {$urandom, $urandom, $urandom, $urandom};
            endcase
            apply(x, y, 1'($urandom % 2), "R1");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule